// File: doc/BRIEF.md
# Header-Credit Threshold Throttle

This block sits beside a transmit MAC and keeps a running count of the header credits the link partner has granted for two request classes: posted (writes) and non-posted (reads). Each transmitted request consumes one credit of its class. Each credit-return update from the partner adds the returned amount back. When the credits left in a class drop below a programmable minimum, the block raises an almost-full flag for that class. The upstream request engine uses the flag to hold back requests of that class.

A minimum set above what the partner grants would stall a class forever. To prevent this, the block limits each effective minimum to the partner's initial grant. The limit is applied when the link comes up, and again on every threshold write made while the link is up. While the link is down, both flags stay raised and both counts stay at zero. A consume pulse that arrives with no credit left is dropped and sets a sticky error bit for its class.

Top module: `credit_throttle`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), both almost-full flags read 1, both effective thresholds read 0 and both underflow bits read 0.
- R2: While the link is down, both almost-full flags are 1 from the clock after link_up is sampled low, whatever the counts and thresholds.
- R3: At the first clock where link_up is sampled high after being low, each class count loads that class's initial-credit input.
- R4: At that same clock, each effective threshold becomes the smaller of the programmed value and the initial credit.
- R5: While the link is up, a class's almost-full flag is 1 exactly when its count is below its effective threshold, and each consume pulse lowers the count by one.
- R6: A credit-return update adds its amount to the count, which saturates at 255 and never wraps.
- R7: A consume pulse while the class count is 0 leaves the count at 0 and sets that class's underflow bit, which stays 1 until reset.
- R8: A consume pulse and a return update for the same class on the same clock apply as one net change (amount minus one).
- R9: A threshold write while the link is up shows on the effective threshold one clock later, limited to that class's stored initial credit.
- R10: The posted and non-posted classes are independent: events in one class never change the other class's count, flag or threshold.
- R11: A threshold write while the link is down is stored unlimited and shows one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link is up |
| p_init | input | 8 | Partner's initial posted header credits |
| np_init | input | 8 | Partner's initial non-posted header credits |
| p_consume | input | 1 | One posted credit used this clock |
| np_consume | input | 1 | One non-posted credit used this clock |
| p_ret_vld | input | 1 | Posted credit return valid |
| p_ret_amt | input | 8 | Posted credits returned |
| np_ret_vld | input | 1 | Non-posted credit return valid |
| np_ret_amt | input | 8 | Non-posted credits returned |
| p_thr_we | input | 1 | Write posted threshold |
| p_thr_wdata | input | 8 | Posted threshold write value |
| np_thr_we | input | 1 | Write non-posted threshold |
| np_thr_wdata | input | 8 | Non-posted threshold write value |
| p_af | output | 1 | Posted almost-full |
| np_af | output | 1 | Non-posted almost-full |
| p_thr_eff | output | 8 | Effective posted threshold |
| np_thr_eff | output | 8 | Effective non-posted threshold |
| p_uflow | output | 1 | Sticky posted underflow error |
| np_uflow | output | 1 | Sticky non-posted underflow error |

## Verification
Every output comes from registers through at most one comparator. Each result is therefore due exactly one rising edge after the inputs that cause it are sampled, whether the input is a consume, a return, a write or a link change. The bench drives all inputs on the falling edge and updates its arithmetic model right after the next rising edge. It compares flags, thresholds and error bits on the following falling edge, so each check lands in the cycle where the result is due. The counts are hidden, so the bench infers them by consuming credits until a flag flips at the predicted count.

// File: rtl/credit_throttle.sv
`timescale 1ns/1ps
module credit_throttle #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  input  logic [CW-1:0] p_init,
  input  logic [CW-1:0] np_init,
  input  logic          p_consume,
  input  logic          np_consume,
  input  logic          p_ret_vld,
  input  logic [CW-1:0] p_ret_amt,
  input  logic          np_ret_vld,
  input  logic [CW-1:0] np_ret_amt,
  input  logic          p_thr_we,
  input  logic [CW-1:0] p_thr_wdata,
  input  logic          np_thr_we,
  input  logic [CW-1:0] np_thr_wdata,
  output logic          p_af,
  output logic          np_af,
  output logic [CW-1:0] p_thr_eff,
  output logic [CW-1:0] np_thr_eff,
  output logic          p_uflow,
  output logic          np_uflow
);
  localparam logic [CW:0] MAXV = {1'b0, {CW{1'b1}}};

  logic          up_q;
  logic          rise;
  logic [CW-1:0] init_v [2];
  logic [CW-1:0] amt    [2];
  logic [CW-1:0] wdata  [2];
  logic [CW-1:0] cnt    [2];
  logic [CW-1:0] thr    [2];
  logic [CW-1:0] init_s [2];
  logic          cons   [2];
  logic          rvld   [2];
  logic          we     [2];
  logic          uf     [2];
  logic          af     [2];

  assign init_v[0] = p_init;      assign init_v[1] = np_init;
  assign amt[0]    = p_ret_amt;   assign amt[1]    = np_ret_amt;
  assign wdata[0]  = p_thr_wdata; assign wdata[1]  = np_thr_wdata;
  assign cons[0]   = p_consume;   assign cons[1]   = np_consume;
  assign rvld[0]   = p_ret_vld;   assign rvld[1]   = np_ret_vld;
  assign we[0]     = p_thr_we;    assign we[1]     = np_thr_we;

  assign rise = link_up & ~up_q;

  always_ff @(posedge clk) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= link_up;
  end

  for (genvar k = 0; k < 2; k++) begin : g_cls
    logic [CW-1:0] cand;
    logic [CW-1:0] lim;
    logic          take;
    logic [CW:0]   sum;

    assign lim  = rise ? init_v[k] : init_s[k];
    assign cand = we[k] ? wdata[k] : thr[k];
    assign take = cons[k] && (cnt[k] != '0);
    assign sum  = {1'b0, cnt[k]} + (rvld[k] ? {1'b0, amt[k]} : '0) - {{CW{1'b0}}, take};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[k]    <= '0;
        thr[k]    <= '0;
        init_s[k] <= '0;
        uf[k]     <= 1'b0;
      end else if (rise) begin
        cnt[k]    <= init_v[k];
        init_s[k] <= init_v[k];
        thr[k]    <= (cand < lim) ? cand : lim;
      end else if (up_q && link_up) begin
        cnt[k] <= (sum > MAXV) ? MAXV[CW-1:0] : sum[CW-1:0];
        if (we[k]) thr[k] <= (wdata[k] < lim) ? wdata[k] : lim;
        if (cons[k] && cnt[k] == '0) uf[k] <= 1'b1;
      end else begin
        cnt[k] <= '0;
        if (we[k]) thr[k] <= wdata[k];
      end
    end

    assign af[k] = ~up_q | (cnt[k] < thr[k]);
  end

  assign p_af       = af[0];
  assign np_af      = af[1];
  assign p_thr_eff  = thr[0];
  assign np_thr_eff = thr[1];
  assign p_uflow    = uf[0];
  assign np_uflow   = uf[1];
endmodule

module credit_throttle_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_q,
  input logic [CW-1:0] p_init,
  input logic [CW-1:0] np_init,
  input logic [CW-1:0] p_cnt,
  input logic [CW-1:0] np_cnt,
  input logic [CW-1:0] p_init_s,
  input logic [CW-1:0] np_init_s,
  input logic [CW-1:0] p_thr_eff,
  input logic [CW-1:0] np_thr_eff,
  input logic          p_af,
  input logic          np_af,
  input logic          p_uflow,
  input logic          np_uflow,
  input logic          p_consume,
  input logic          p_ret_vld
);
  a_r2_down_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !up_q |-> (p_af && np_af));

  a_r4_rise_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !$past(up_q)) |-> (p_thr_eff <= $past(p_init) && np_thr_eff <= $past(np_init)));

  a_r9_thr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (p_thr_eff <= p_init_s && np_thr_eff <= np_init_s));

  a_r7_sticky_uflow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p_uflow) |-> p_uflow) and ($past(np_uflow) |-> np_uflow));

  a_r7_zero_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(up_q) && $past(p_consume) && $past(p_cnt) == '0 && !$past(p_ret_vld))
      |-> p_cnt == '0);

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(up_q) && $past(p_ret_vld) && !$past(p_consume)) |-> p_cnt >= $past(p_cnt));
endmodule

bind credit_throttle credit_throttle_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_q(up_q),
  .p_init(p_init), .np_init(np_init),
  .p_cnt(cnt[0]), .np_cnt(cnt[1]),
  .p_init_s(init_s[0]), .np_init_s(init_s[1]),
  .p_thr_eff(p_thr_eff), .np_thr_eff(np_thr_eff),
  .p_af(p_af), .np_af(np_af),
  .p_uflow(p_uflow), .np_uflow(np_uflow),
  .p_consume(p_consume), .p_ret_vld(p_ret_vld)
);

// File: tb/test_credit_throttle.sv
`timescale 1ns/1ps
module test_credit_throttle;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0;
  logic [7:0] init_v [2];
  logic       cons [2];
  logic       rvld [2];
  logic [7:0] amt  [2];
  logic       we   [2];
  logic [7:0] wd   [2];
  logic p_af, np_af, p_uflow, np_uflow;
  logic [7:0] p_thr_eff, np_thr_eff;

  int n_chk = 0;
  int n_fail = 0;

  int m_up;
  int m_cnt [2];
  int m_thr [2];
  int m_ins [2];
  int m_uf  [2];

  always #5 clk = ~clk;

  credit_throttle i_credit_throttle (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .p_init(init_v[0]), .np_init(init_v[1]),
    .p_consume(cons[0]), .np_consume(cons[1]),
    .p_ret_vld(rvld[0]), .p_ret_amt(amt[0]),
    .np_ret_vld(rvld[1]), .np_ret_amt(amt[1]),
    .p_thr_we(we[0]), .p_thr_wdata(wd[0]),
    .np_thr_we(we[1]), .np_thr_wdata(wd[1]),
    .p_af(p_af), .np_af(np_af),
    .p_thr_eff(p_thr_eff), .np_thr_eff(np_thr_eff),
    .p_uflow(p_uflow), .np_uflow(np_uflow)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_step();
    int rise;
    if (!rst_n) begin
      m_up = 0;
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_thr[k] = 0; m_ins[k] = 0; m_uf[k] = 0;
      end
      return;
    end
    rise = (link_up && !m_up) ? 1 : 0;
    for (int k = 0; k < 2; k++) begin
      if (rise) begin
        m_thr[k] = min2(we[k] ? int'(wd[k]) : m_thr[k], int'(init_v[k]));
        m_cnt[k] = init_v[k];
        m_ins[k] = init_v[k];
      end else if (m_up && link_up) begin
        int nxt;
        nxt = m_cnt[k] + (rvld[k] ? int'(amt[k]) : 0) - ((cons[k] && m_cnt[k] > 0) ? 1 : 0);
        if (cons[k] && m_cnt[k] == 0) m_uf[k] = 1;
        m_cnt[k] = min2(nxt, 255);
        if (we[k]) m_thr[k] = min2(int'(wd[k]), m_ins[k]);
      end else begin
        m_cnt[k] = 0;
        if (we[k]) m_thr[k] = wd[k];
      end
    end
    m_up = link_up ? 1 : 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R5 p_af model", int'(p_af), (!m_up || m_cnt[0] < m_thr[0]) ? 1 : 0);
    chk("R5 np_af model", int'(np_af), (!m_up || m_cnt[1] < m_thr[1]) ? 1 : 0);
    chk("R9 p_thr model", int'(p_thr_eff), m_thr[0]);
    chk("R9 np_thr model", int'(np_thr_eff), m_thr[1]);
    chk("R7 p_uflow model", int'(p_uflow), m_uf[0]);
    chk("R7 np_uflow model", int'(np_uflow), m_uf[1]);
  endtask

  task automatic idle();
    for (int k = 0; k < 2; k++) begin
      cons[k] = 1'b0; rvld[k] = 1'b0; amt[k] = '0; we[k] = 1'b0; wd[k] = '0;
    end
  endtask

  task automatic consume_n(int k, int n);
    for (int i = 0; i < n; i++) begin
      cons[k] = 1'b1; tick();
    end
    cons[k] = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle();
    init_v[0] = '0; init_v[1] = '0;
    @(negedge clk);
    tick(); tick(); tick();
    chk("R1 p_af", int'(p_af), 1);
    chk("R1 np_af", int'(np_af), 1);
    chk("R1 p_thr", int'(p_thr_eff), 0);
    chk("R1 np_thr", int'(np_thr_eff), 0);
    chk("R1 uflow", int'(p_uflow) + int'(np_uflow), 0);
    rst_n = 1'b1;
    tick();

    we[0] = 1'b1; wd[0] = 8'd40; we[1] = 1'b1; wd[1] = 8'd200;
    tick(); idle();
    chk("R11 p_thr down", int'(p_thr_eff), 40);
    chk("R11 np_thr down", int'(np_thr_eff), 200);
    chk("R2 af down", int'(p_af) + int'(np_af), 2);

    init_v[0] = 8'd50; init_v[1] = 8'd20; link_up = 1'b1;
    tick();
    chk("R4 p_thr clamp", int'(p_thr_eff), 40);
    chk("R4 np_thr clamp", int'(np_thr_eff), 20);
    chk("R3 p_af load", int'(p_af), 0);
    chk("R3 np_af load", int'(np_af), 0);

    consume_n(1, 1);
    chk("R5 np_af below", int'(np_af), 1);
    chk("R10 p_af untouched", int'(p_af), 0);

    consume_n(0, 10);
    chk("R5 p_af at thr", int'(p_af), 0);
    consume_n(0, 1);
    chk("R5 p_af below", int'(p_af), 1);

    rvld[0] = 1'b1; amt[0] = 8'd255; tick(); idle();
    chk("R6 p_af after sat", int'(p_af), 0);
    consume_n(0, 215);
    chk("R6 p_af at 40", int'(p_af), 0);
    consume_n(0, 1);
    chk("R6 p_af at 39", int'(p_af), 1);

    cons[0] = 1'b1; rvld[0] = 1'b1; amt[0] = 8'd1; tick(); idle();
    chk("R8 net zero", int'(p_af), 1);
    rvld[0] = 1'b1; amt[0] = 8'd1; tick(); idle();
    chk("R8 return alone", int'(p_af), 0);

    consume_n(1, 19);
    chk("R7 no uflow yet", int'(np_uflow), 0);
    consume_n(1, 1);
    chk("R7 uflow set", int'(np_uflow), 1);
    chk("R10 p_uflow clear", int'(p_uflow), 0);
    rvld[1] = 1'b1; amt[1] = 8'd1; tick(); idle();
    we[1] = 1'b1; wd[1] = 8'd1; tick(); idle();
    chk("R9 np_thr write", int'(np_thr_eff), 1);
    chk("R7 count held at zero", int'(np_af), 0);
    chk("R7 uflow sticky", int'(np_uflow), 1);

    we[0] = 1'b1; wd[0] = 8'd200; tick(); idle();
    chk("R9 p_thr clamp write", int'(p_thr_eff), 50);
    chk("R9 p_af new thr", int'(p_af), 1);

    link_up = 1'b0; tick();
    chk("R2 p_af drop", int'(p_af), 1);
    chk("R2 np_af drop", int'(np_af), 1);

    for (int c = 0; c < 5000; c++) begin
      idle();
      if ($urandom_range(0, 149) == 0) link_up = ~link_up;
      for (int k = 0; k < 2; k++) begin
        init_v[k] = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 4)) : 8'($urandom_range(0, 255));
        cons[k] = ($urandom_range(0, 1) == 1);
        if ($urandom_range(0, 7) == 0) begin
          rvld[k] = 1'b1;
          amt[k] = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 6));
        end
        if ($urandom_range(0, 29) == 0) begin
          we[k] = 1'b1;
          wd[k] = 8'($urandom_range(0, 255));
        end
      end
      tick();
    end
    idle();
    summary();
  end
endmodule